// File: doc/BRIEF.md
# Synthesizer Three-Wire Register Loader

This block loads the three configuration words of a frequency synthesizer over a serial link made of a shift clock, a data line and a latch strobe. A single start strobe captures three words: a function/control word, a reference-divider word and an N-divider word. The block then shifts each word out as 24 bits and closes each word with its own latch pulse. The words always go out in the same order.

The timing unit is one interval of `div_i + 1` system clock cycles. Each bit spends one interval with the shift clock low and the data already valid, then one interval with the shift clock high. Each latch pulse is one interval long. One interval of quiet line separates a latch pulse from the next word. The shift clock and data line are shared by up to four synthesizers. A channel index picks which synthesizer's latch line is pulsed.

The host reads `busy_o` to know when a load is running. A one-cycle `done_o` marks the end of the load.

Top module: `pll3w_loader`

## Requirements
- R1: Only bits 23..0 of each word input are sent; bits above bit 23 never reach the data line.
- R2: Each word is sent most significant bit first, 24 shift-clock pulses per word. The data line takes its value at least one cycle before the shift clock rises, and holds it while the shift clock is high.
- R3: With interval T = `div_i` + 1 cycles, sampled at start, each shift-clock high phase lasts exactly T cycles and each low phase before a bit lasts T cycles.
- R4: After the 24th bit of a word, the latch line is high for exactly T cycles, and the shift clock is low throughout.
- R5: The words are sent in a fixed order: the control word, then the reference word, then the N word.
- R6: After reset and whenever the block is idle, the shift clock, the data line and all latch lines are low, and `busy_o` and `done_o` are low.
- R7: `chan_i`, sampled at start, selects latch line `le_o[chan_i]`. No other latch line is ever high. The shift clock and data line are common to all channels.
- R8: A start request while `busy_o` is high is ignored. A load in progress does not restart, and its words, channel and interval do not change.
- R9: `busy_o` rises in the cycle after an accepted start and stays high for exactly 149*T cycles. That is three words of 49 intervals each, plus two gap intervals. `done_o` is then high for exactly one cycle while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| chan_i | input | CH_W | Index of the synthesizer whose latch line is pulsed |
| div_i | input | DIV_W | Interval length minus one, in clock cycles |
| ctl_word_i | input | IN_W | Control/function word, sent first |
| ref_word_i | input | IN_W | Reference-divider word, sent second |
| ncnt_word_i | input | IN_W | N-divider word, sent last |
| sclk_o | output | 1 | Shared serial shift clock |
| sdata_o | output | 1 | Shared serial data |
| le_o | output | NUM_CH | Per-synthesizer latch strobes |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse at end of load |

## Verification
Every result has a fixed due time measured from the accepting clock edge:
- `busy_o` is due at the first sample after start.
- Each shift-clock high phase and each latch pulse must last exactly T samples.
- `done_o` is due exactly 149*T busy samples after start, and must be gone at the next sample.

The monitor samples on the falling clock edge, half a cycle after outputs change. It counts samples in each phase and checks the counts on the falling edge of that phase. On each latch rise it pops the expected word and channel from the scoreboard queue, so a word in the wrong place or with the wrong content shows up at once. After each load, idle samples confirm that a start ignored while busy did not begin a second load.

// File: rtl/pll3w_pkg.sv
package pll3w_pkg;
  localparam int unsigned WORD_W    = 24;
  localparam int unsigned NUM_WORDS = 3;
  localparam int unsigned BIT_W     = $clog2(WORD_W);
  localparam int unsigned FRAME_INTERVALS = NUM_WORDS * (2 * WORD_W + 1) + (NUM_WORDS - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_LATCH,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/pll3w_interval.sv
module pll3w_interval #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pll3w_word_shift.sv
module pll3w_word_shift
  import pll3w_pkg::*;
#(
  parameter int unsigned IN_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [NUM_WORDS*IN_W-1:0] words_i,
  input  logic                      shift_i,
  input  logic                      next_i,
  output logic                      msb_o,
  output logic                      last_o
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic [WORD_W-1:0] masked [NUM_WORDS];
  logic [WORD_W-1:0] bank_q [NUM_WORDS];
  logic [WORD_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_nxt;

  // keep the low WORD_W bits of each slot; the rest is dropped
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_mask
    assign masked[g] = words_i[g*IN_W +: WORD_W];
    if (IN_W > WORD_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^words_i[g*IN_W+WORD_W +: IN_W-WORD_W];
    end
  end

  assign idx_nxt = idx_q + 1'b1;
  assign msb_o   = sr_q[WORD_W-1];
  assign last_o  = (idx_q == IDX_W'(NUM_WORDS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) bank_q[i] <= '0;
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NUM_WORDS; i++) bank_q[i] <= masked[i];
      sr_q  <= masked[0];
      idx_q <= '0;
    end else if (next_i && !last_o) begin
      idx_q <= idx_nxt;
      sr_q  <= bank_q[idx_nxt];
    end else if (shift_i) begin
      sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pll3w_le_route.sv
module pll3w_le_route #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic              en_i,
  input  logic [CH_W-1:0]   sel_i,
  output logic [NUM_CH-1:0] le_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign le_o[g] = en_i && (sel_i == CH_W'(g));
  end
endmodule

// File: rtl/pll3w_loader.sv
module pll3w_loader
  import pll3w_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned IN_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [IN_W-1:0]   ctl_word_i,
  input  logic [IN_W-1:0]   ref_word_i,
  input  logic [IN_W-1:0]   ncnt_word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic [NUM_CH-1:0] le_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [DIV_W-1:0] div_q;
  logic [CH_W-1:0]  chan_q;
  logic             done_q;
  logic             tick;
  logic             accept;
  logic             shift;
  logic             next_word;
  logic             msb;
  logic             last_word;
  logic             in_bit;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign shift     = (state_q == ST_BIT_HI) && tick && (bit_q != '0);
  assign next_word = (state_q == ST_GAP) && tick;
  assign in_bit    = (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI);

  pll3w_interval #(.DIV_W(DIV_W)) u_interval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q != ST_IDLE),
    .limit_i (div_q),
    .tick_o  (tick)
  );

  // slot 0 goes first: control, then reference, then N
  pll3w_word_shift #(.IN_W(IN_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .words_i ({ncnt_word_i, ref_word_i, ctl_word_i}),
    .shift_i (shift),
    .next_i  (next_word),
    .msb_o   (msb),
    .last_o  (last_word)
  );

  pll3w_le_route #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_route (
    .en_i  (state_q == ST_LATCH),
    .sel_i (chan_q),
    .le_o  (le_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      div_q   <= '0;
      chan_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_BIT_LO;
          bit_q   <= BIT_W'(WORD_W-1);
          div_q   <= div_i;
          chan_q  <= chan_i;
        end
        ST_BIT_LO: if (tick) state_q <= ST_BIT_HI;
        ST_BIT_HI: if (tick) begin
          if (bit_q == '0) state_q <= ST_LATCH;
          else begin
            bit_q   <= bit_q - 1'b1;
            state_q <= ST_BIT_LO;
          end
        end
        ST_LATCH: if (tick) begin
          if (last_word) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (tick) begin
          state_q <= ST_BIT_LO;
          bit_q   <= BIT_W'(WORD_W-1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o  = (state_q == ST_BIT_HI);
  assign sdata_o = in_bit && msb;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/pll3w_loader_chk.sv
module pll3w_loader_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              sclk_o,
  input logic              sdata_o,
  input logic [NUM_CH-1:0] le_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sdata_o && (le_o == '0)));

  a_r7_le_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(le_o));

  a_r4_le_clk_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_o != '0) |-> !sclk_o);

  a_r2_data_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(sdata_o));

  a_r2_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_busy_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind pll3w_loader pll3w_loader_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .sclk_o  (sclk_o),
  .sdata_o (sdata_o),
  .le_o    (le_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/test_pll3w_loader.sv
module test_pll3w_loader;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int DIV_W  = 8;
  localparam int IN_W   = 32;
  localparam int FRAME_T = 149;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CH_W-1:0]  chan_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic [IN_W-1:0]  ctl_word_i = '0, ref_word_i = '0, ncnt_word_i = '0;
  logic sclk_o, sdata_o, busy_o, done_o;
  logic [NUM_CH-1:0] le_o;

  always #4 clk = ~clk;

  pll3w_loader #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DIV_W(DIV_W), .IN_W(IN_W)) i_pll3w_loader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .chan_i(chan_i), .div_i(div_i),
    .ctl_word_i(ctl_word_i), .ref_word_i(ref_word_i), .ncnt_word_i(ncnt_word_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int exp_t = 1;
  int cyc = 0;
  logic [25:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  // monitor
  logic prev_sclk = 1'b0, prev_sdata = 1'b0, prev_done = 1'b0;
  logic [NUM_CH-1:0] prev_le = '0;
  logic [23:0] cap = '0;
  int nbits = 0, hi_len = 0, le_len = 0, busy_len = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (sclk_o && !prev_sclk) begin
        chk(sdata_o == prev_sdata, "R2", "data setup before clock rise", sdata_o, prev_sdata);
        cap = {cap[22:0], sdata_o};
        nbits++;
      end
      if (sclk_o) hi_len++;
      if (!sclk_o && prev_sclk) begin
        chk(hi_len == exp_t, "R3", "clock high width", hi_len, exp_t);
        hi_len = 0;
      end
      if ((le_o != '0) && (prev_le == '0)) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected latch pulse", le_o, 0);
        end else begin
          logic [25:0] it;
          it = exp_q.pop_front();
          chk(nbits == 24, "R2", "bits per word", nbits, 24);
          chk(cap == it[23:0], "R1 R5", "word content and order", cap, it[23:0]);
          chk(le_o == (NUM_CH'(1) << it[25:24]), "R7", "latch channel", le_o,
              NUM_CH'(1) << it[25:24]);
        end
        nbits = 0;
      end
      if (le_o != '0) le_len++;
      if ((le_o == '0) && (prev_le != '0)) begin
        chk(le_len == exp_t, "R4", "latch width", le_len, exp_t);
        le_len = 0;
      end
      if (busy_o) busy_len++;
      if (done_o) begin
        chk(busy_len == FRAME_T * exp_t, "R9 R3", "busy length", busy_len, FRAME_T * exp_t);
        chk(exp_q.size() == 0, "R5", "words left unsent", exp_q.size(), 0);
        busy_len = 0;
      end
      if (prev_done)
        chk(!done_o, "R9", "done width", done_o, 0);
      prev_sclk  = sclk_o;
      prev_sdata = sdata_o;
      prev_le    = le_o;
      prev_done  = done_o;
    end
  end

  // driver
  task automatic run_frame(input logic [CH_W-1:0] ch, input int dv,
                           input logic [IN_W-1:0] c, input logic [IN_W-1:0] r,
                           input logic [IN_W-1:0] n, input bit inject);
    @(negedge clk);
    exp_t = dv + 1;
    exp_q.push_back({ch, c[23:0]});
    exp_q.push_back({ch, r[23:0]});
    exp_q.push_back({ch, n[23:0]});
    chan_i = ch; div_i = DIV_W'(dv);
    ctl_word_i = c; ref_word_i = r; ncnt_word_i = n;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
    if (inject) begin
      repeat (7) @(negedge clk);
      chan_i = ~ch; div_i = '0;
      ctl_word_i = ~c; ref_word_i = ~r; ncnt_word_i = ~n;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o && !sclk_o && !sdata_o && (le_o == '0), "R6",
        "idle lines after load", {busy_o, done_o, sclk_o, sdata_o, le_o}, 0);
    begin
      bit stayed;
      stayed = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (busy_o) stayed = 1'b0;
      end
      chk(stayed, "R8", "no restart after load", !stayed, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sclk_o && !sdata_o && (le_o == '0) && !busy_o && !done_o, "R6", "reset state",
        {sclk_o, sdata_o, le_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !sclk_o, "R6", "idle after reset release", {busy_o, sclk_o}, 0);
    run_frame(2'd0, 1, 32'hFF9F_8092, 32'h1200_0410, 32'h8003_E801, 1'b0);
    run_frame(2'd3, 3, 32'h00A5_A5A5, 32'h005A_5A5A, 32'hFFFF_FFFF, 1'b1);
    run_frame(2'd1, 0, 32'h0080_0001, 32'h0000_0000, 32'h00C0_0003, 1'b0);
    run_frame(2'd2, 2, 32'h0004_DE71, 32'h7705_9A31, 32'h0123_4567, 1'b1);
    summary();
  end
endmodule